// File: doc/BRIEF.md
# Tiered Register Write-Lock Controller

This block holds a set of timer configuration fields and filters every register write against a lock level. The lock level has four values. A higher level protects more fields, and every field protected at one level stays protected at all higher levels. Software can set the lock level only once after reset. After that, protected fields stay frozen until the next reset.

Protection works on single fields, not on whole registers. A write with a per-bit mask can touch protected and unprotected fields in the same word. The protected bits keep their old value and the unprotected bits take the new data. The timer logic that uses these fields lies outside this block and only reads the outputs.

The write bus has an enable, an address, a data word and a per-bit write mask. The address map is as follows.

| Address | Bits | Field | Tier |
|---|---|---|---|
| 0 | [7:0] | dead-time code | 1 |
| 0 | [9:8] | lock level | write-once |
| 0 | [10] | idle-mode off-state | 2 |
| 0 | [11] | run-mode off-state | 2 |
| 0 | [12] | break enable | 1 |
| 0 | [13] | break polarity | 1 |
| 0 | [14] | automatic output enable | 1 |
| 1 | [CH-1:0] | main-output idle states | 1 |
| 1 | [2CH-1:CH] | complementary-output idle states | 1 |
| 2 | [CH-1:0] | main-output polarities | 2 |
| 2 | [2CH-1:CH] | complementary-output polarities | 2 |
| 3+i | [2:0] | compare mode of channel i | 3 |
| 3+i | [3] | preload enable of channel i | 3 |

Top module: `wrlock_ctrl`

## Requirements
- R1: After reset, the lock level and every configuration output are zero.
- R2: At lock level 0, every field at addresses 0 to 3+CH-1 takes a write. The layout is the one in the address map above.
- R3: Only the bits whose wr_mask bit is 1 change. The data bits under a 0 mask bit have no effect.
- R4: The first write to address 0 that has either of wr_mask[9:8] set loads the lock level from wr_data[9:8]. Every later write to the lock level is ignored until reset.
- R5: A first lock write of level 0 also uses up the one write. The lock stays at 0 until reset, and the unprotected state remains writable.
- R6: At level 1 or higher, writes to the tier-1 fields are ignored: dead-time code, break enable, break polarity, automatic output enable and all idle states. Tier-2 and tier-3 fields still take writes at level 1.
- R7: At level 2 or higher, writes to the tier-2 fields are also ignored: all polarities, run-mode off-state and idle-mode off-state. Tier-3 fields still take writes at level 2.
- R8: At level 3, writes to the tier-3 fields are also ignored: the compare mode and preload enable of every channel.
- R9: A write that covers both protected and unprotected fields of one word updates only the unprotected ones.
- R10: The write that sets the lock level is filtered against the level in force before it. The other fields of that same word still take their new values while the level is 0.
- R11: A write to an unmapped address, or a cycle with wr_en low, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Word address |
| wr_data | input | DW | Write data |
| wr_mask | input | DW | Per-bit write mask, 1 = write this bit |
| lock_level | output | 2 | Current lock level |
| dead_code | output | 8 | Dead-time code |
| brk_en | output | 1 | Break enable |
| brk_pol | output | 1 | Break polarity |
| auto_oe | output | 1 | Automatic output enable |
| idle_off | output | 1 | Idle-mode off-state |
| run_off | output | 1 | Run-mode off-state |
| idle_main | output | CH | Main-output idle states |
| idle_comp | output | CH | Complementary-output idle states |
| pol_main | output | CH | Main-output polarities |
| pol_comp | output | CH | Complementary-output polarities |
| oc_mode | output | CH*MODE_W | Compare mode, channel i at [i*MODE_W +: MODE_W] |
| oc_preload | output | CH | Preload enable per channel |

## Verification
The hardest case to reach is the boundary cycle. There, a single write to address 0 sets the lock level and also changes the fields beside it. The fields must be judged against the old level, and every later write must see the new one. The stimulus first fills all fields at level 0. It then issues the lock write together with a dead-time change and checks that the change lands. Right after that, it repeats the write with a different level and code and checks that both are refused. Separate reset sections reach each of the levels 0, 2 and 3 directly. This includes a level-0 lock write followed by an attempt to raise the lock.

// File: rtl/wrlock_pkg.sv
`timescale 1ns/1ps
package wrlock_pkg;
    typedef enum logic [1:0] {
        LOCK_OFF = 2'd0,
        LOCK_L1  = 2'd1,
        LOCK_L2  = 2'd2,
        LOCK_L3  = 2'd3
    } lock_t;

    // word addresses
    localparam int ADR_CFG   = 0;
    localparam int ADR_IDLE  = 1;
    localparam int ADR_POL   = 2;
    localparam int ADR_MODE0 = 3;

    // bit positions inside the configuration word
    localparam int DEAD_W    = 8;
    localparam int LOCK_LSB  = 8;
    localparam int T2_LSB    = 10;  // idle_off, run_off
    localparam int T2_W      = 2;
    localparam int T1_LSB    = 12;  // brk_en, brk_pol, auto_oe
    localparam int T1_W      = 3;
endpackage

// File: rtl/wrlock_tier_gate.sv
`timescale 1ns/1ps
module wrlock_tier_gate
    import wrlock_pkg::*;
(
    input  lock_t level,
    output logic  allow_t1,
    output logic  allow_t2,
    output logic  allow_t3
);
    // each level removes one more tier from the writable set
    always_comb begin
        allow_t1 = (level == LOCK_OFF);
        allow_t2 = (level == LOCK_OFF) || (level == LOCK_L1);
        allow_t3 = (level != LOCK_L3);
    end
endmodule

// File: rtl/wrlock_field_merge.sv
`timescale 1ns/1ps
module wrlock_field_merge #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] new_val,
    input  logic [W-1:0] mask,
    output logic [W-1:0] merged
);
    always_comb begin
        merged = en ? ((old_val & ~mask) | (new_val & mask)) : old_val;
    end
endmodule

// File: rtl/wrlock_ctrl.sv
`timescale 1ns/1ps
module wrlock_ctrl
    import wrlock_pkg::*;
#(
    parameter int CH     = 4,
    parameter int AW     = 3,
    parameter int DW     = 16,
    parameter int MODE_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [DW-1:0]        wr_mask,
    output logic [1:0]           lock_level,
    output logic [7:0]           dead_code,
    output logic                 brk_en,
    output logic                 brk_pol,
    output logic                 auto_oe,
    output logic                 idle_off,
    output logic                 run_off,
    output logic [CH-1:0]        idle_main,
    output logic [CH-1:0]        idle_comp,
    output logic [CH-1:0]        pol_main,
    output logic [CH-1:0]        pol_comp,
    output logic [CH*MODE_W-1:0] oc_mode,
    output logic [CH-1:0]        oc_preload
);
    localparam int CHW  = MODE_W + 1;   // mode plus preload per channel
    localparam int PW   = 2 * CH;       // main plus complementary bits
    localparam int ALLM = CH * CHW;

    typedef struct packed {
        lock_t             lock;
        logic              used;
        logic [DEAD_W-1:0] dead;
        logic [T1_W-1:0]   t1;
        logic [T2_W-1:0]   t2;
        logic [PW-1:0]     idle;
        logic [PW-1:0]     pol;
        logic [ALLM-1:0]   modes;
    } state_t;

    state_t st_d, st_q;

    logic allow_t1, allow_t2, allow_t3;
    logic hit_cfg, hit_idle, hit_pol, lock_wr;
    logic [CH-1:0] hit_mode;

    logic [DEAD_W-1:0] dead_m;
    logic [T1_W-1:0]   t1_m;
    logic [T2_W-1:0]   t2_m;
    logic [1:0]        lock_m;
    logic [PW-1:0]     idle_m, pol_m;
    logic [ALLM-1:0]   modes_m;

    always_comb begin
        hit_cfg  = wr_en && (wr_addr == AW'(ADR_CFG));
        hit_idle = wr_en && (wr_addr == AW'(ADR_IDLE));
        hit_pol  = wr_en && (wr_addr == AW'(ADR_POL));
        lock_wr  = hit_cfg && !st_q.used && (|wr_mask[LOCK_LSB +: 2]);
    end

    wrlock_tier_gate u_gate (
        .level    (st_q.lock),
        .allow_t1 (allow_t1),
        .allow_t2 (allow_t2),
        .allow_t3 (allow_t3)
    );

    wrlock_field_merge #(.W(DEAD_W)) u_dead (
        .en (hit_cfg && allow_t1), .old_val (st_q.dead),
        .new_val (wr_data[DEAD_W-1:0]), .mask (wr_mask[DEAD_W-1:0]), .merged (dead_m)
    );
    wrlock_field_merge #(.W(T1_W)) u_t1 (
        .en (hit_cfg && allow_t1), .old_val (st_q.t1),
        .new_val (wr_data[T1_LSB +: T1_W]), .mask (wr_mask[T1_LSB +: T1_W]), .merged (t1_m)
    );
    wrlock_field_merge #(.W(T2_W)) u_t2 (
        .en (hit_cfg && allow_t2), .old_val (st_q.t2),
        .new_val (wr_data[T2_LSB +: T2_W]), .mask (wr_mask[T2_LSB +: T2_W]), .merged (t2_m)
    );
    wrlock_field_merge #(.W(2)) u_lock (
        .en (lock_wr), .old_val (st_q.lock),
        .new_val (wr_data[LOCK_LSB +: 2]), .mask (wr_mask[LOCK_LSB +: 2]), .merged (lock_m)
    );
    wrlock_field_merge #(.W(PW)) u_idle (
        .en (hit_idle && allow_t1), .old_val (st_q.idle),
        .new_val (wr_data[PW-1:0]), .mask (wr_mask[PW-1:0]), .merged (idle_m)
    );
    wrlock_field_merge #(.W(PW)) u_pol (
        .en (hit_pol && allow_t2), .old_val (st_q.pol),
        .new_val (wr_data[PW-1:0]), .mask (wr_mask[PW-1:0]), .merged (pol_m)
    );

    for (genvar i = 0; i < CH; i++) begin : g_chan
        always_comb hit_mode[i] = wr_en && (wr_addr == AW'(ADR_MODE0 + i));

        wrlock_field_merge #(.W(CHW)) u_mode (
            .en      (hit_mode[i] && allow_t3),
            .old_val (st_q.modes[i*CHW +: CHW]),
            .new_val (wr_data[CHW-1:0]),
            .mask    (wr_mask[CHW-1:0]),
            .merged  (modes_m[i*CHW +: CHW])
        );

        assign oc_mode[i*MODE_W +: MODE_W] = st_q.modes[i*CHW +: MODE_W];
        assign oc_preload[i]               = st_q.modes[i*CHW + MODE_W];
    end

    always_comb begin
        st_d       = st_q;
        st_d.dead  = dead_m;
        st_d.t1    = t1_m;
        st_d.t2    = t2_m;
        st_d.idle  = idle_m;
        st_d.pol   = pol_m;
        st_d.modes = modes_m;
        st_d.lock  = lock_t'(lock_m);
        if (lock_wr) st_d.used = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_level = st_q.lock;
    assign dead_code  = st_q.dead;
    assign idle_off   = st_q.t2[0];
    assign run_off    = st_q.t2[1];
    assign brk_en     = st_q.t1[0];
    assign brk_pol    = st_q.t1[1];
    assign auto_oe    = st_q.t1[2];
    assign idle_main  = st_q.idle[CH-1:0];
    assign idle_comp  = st_q.idle[PW-1:CH];
    assign pol_main   = st_q.pol[CH-1:0];
    assign pol_comp   = st_q.pol[PW-1:CH];
endmodule

// File: rtl/wrlock_ctrl_chk.sv
`timescale 1ns/1ps
module wrlock_ctrl_chk #(
    parameter int CH     = 4,
    parameter int MODE_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [1:0]           lock_level,
    input logic [7:0]           dead_code,
    input logic                 brk_en,
    input logic                 brk_pol,
    input logic                 auto_oe,
    input logic                 idle_off,
    input logic                 run_off,
    input logic [CH-1:0]        idle_main,
    input logic [CH-1:0]        idle_comp,
    input logic [CH-1:0]        pol_main,
    input logic [CH-1:0]        pol_comp,
    input logic [CH*MODE_W-1:0] oc_mode,
    input logic [CH-1:0]        oc_preload
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (lock_level == 2'd0 && dead_code == 8'd0 && oc_mode == '0));

    p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_level != 2'd0) |=> $stable(lock_level));

    p_t1_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_level != 2'd0) |=> $stable({dead_code, brk_en, brk_pol, auto_oe, idle_main, idle_comp}));

    p_t2_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_level >= 2'd2) |=> $stable({pol_main, pol_comp, run_off, idle_off}));

    p_t3_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_level == 2'd3) |=> $stable({oc_mode, oc_preload}));

    p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({lock_level, dead_code, brk_en, brk_pol, auto_oe, idle_off, run_off,
                            idle_main, idle_comp, pol_main, pol_comp, oc_mode, oc_preload}));
endmodule

bind wrlock_ctrl wrlock_ctrl_chk #(.CH(CH), .MODE_W(MODE_W)) u_chk (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .lock_level (lock_level),
    .dead_code (dead_code), .brk_en (brk_en), .brk_pol (brk_pol), .auto_oe (auto_oe),
    .idle_off (idle_off), .run_off (run_off), .idle_main (idle_main), .idle_comp (idle_comp),
    .pol_main (pol_main), .pol_comp (pol_comp), .oc_mode (oc_mode), .oc_preload (oc_preload)
);

// File: tb/test_wrlock_ctrl.sv
`timescale 1ns/1ps
module test_wrlock_ctrl;
    localparam int CH = 4, AW = 3, DW = 16, MODE_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] wr_mask = '0;
    logic [1:0] lock_level;
    logic [7:0] dead_code;
    logic brk_en, brk_pol, auto_oe, idle_off, run_off;
    logic [CH-1:0] idle_main, idle_comp, pol_main, pol_comp, oc_preload;
    logic [CH*MODE_W-1:0] oc_mode;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wrlock_ctrl #(.CH(CH), .AW(AW), .DW(DW), .MODE_W(MODE_W)) i_wrlock_ctrl (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .wr_mask (wr_mask), .lock_level (lock_level),
        .dead_code (dead_code), .brk_en (brk_en), .brk_pol (brk_pol), .auto_oe (auto_oe),
        .idle_off (idle_off), .run_off (run_off), .idle_main (idle_main), .idle_comp (idle_comp),
        .pol_main (pol_main), .pol_comp (pol_comp), .oc_mode (oc_mode), .oc_preload (oc_preload)
    );

    // observation views, bit order follows the register layout
    wire [4:0] misc_v  = {auto_oe, brk_pol, brk_en, run_off, idle_off};
    wire [7:0] idle_v  = {idle_comp, idle_main};
    wire [7:0] pol_v   = {pol_comp, pol_main};
    wire [3:0] mode0_v = {oc_preload[0], oc_mode[2:0]};
    wire [3:0] mode1_v = {oc_preload[1], oc_mode[5:3]};
    wire [3:0] mode3_v = {oc_preload[3], oc_mode[11:9]};

    typedef struct packed {
        logic [2:0]  addr;
        logic [15:0] data;
        logic [15:0] mask;
        logic [1:0]  e_lock;
        logic [7:0]  e_dead;
        logic [4:0]  e_misc;
        logic [7:0]  e_idle;
        logic [7:0]  e_pol;
        logic [3:0]  e_mode;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{3'd0, 16'h00A5, 16'h00FF, 2'd0, 8'hA5, 5'h00, 8'h00, 8'h00, 4'h0, 4'd2},  // R2 dead code
        '{3'd0, 16'h7C00, 16'h7C00, 2'd0, 8'hA5, 5'h1F, 8'h00, 8'h00, 4'h0, 4'd2},  // R2 single bits
        '{3'd0, 16'h00FF, 16'h000F, 2'd0, 8'hAF, 5'h1F, 8'h00, 8'h00, 4'h0, 4'd3},  // R3 partial mask
        '{3'd2, 16'h005A, 16'h00FF, 2'd0, 8'hAF, 5'h1F, 8'h00, 8'h5A, 4'h0, 4'd2},  // R2 polarity
        '{3'd3, 16'h000D, 16'h000F, 2'd0, 8'hAF, 5'h1F, 8'h00, 8'h5A, 4'hD, 4'd2},  // R2 mode ch0
        '{3'd7, 16'hFFFF, 16'hFFFF, 2'd0, 8'hAF, 5'h1F, 8'h00, 8'h5A, 4'hD, 4'd11}, // R11 unmapped
        '{3'd0, 16'h0133, 16'h03FF, 2'd1, 8'h33, 5'h1F, 8'h00, 8'h5A, 4'hD, 4'd10}, // R10 lock+dead
        '{3'd0, 16'h0311, 16'h03FF, 2'd1, 8'h33, 5'h1F, 8'h00, 8'h5A, 4'hD, 4'd4},  // R4 second lock write
        '{3'd0, 16'h0000, 16'h7C00, 2'd1, 8'h33, 5'h1C, 8'h00, 8'h5A, 4'hD, 4'd9},  // R9 mixed word
        '{3'd2, 16'h00C3, 16'h00FF, 2'd1, 8'h33, 5'h1C, 8'h00, 8'hC3, 4'hD, 4'd6},  // R6 tier 2 open
        '{3'd3, 16'h0002, 16'h000F, 2'd1, 8'h33, 5'h1C, 8'h00, 8'hC3, 4'h2, 4'd6},  // R6 tier 3 open
        '{3'd1, 16'h00FF, 16'h00FF, 2'd1, 8'h33, 5'h1C, 8'h00, 8'hC3, 4'h2, 4'd6}   // R6 idle blocked
    };

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // drive on a falling edge, write lands at the next rising edge, sample at the falling edge after it
    task automatic do_write(input logic [2:0] a, input logic [15:0] d, input logic [15:0] m);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        wr_mask = m;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check(1, "lock after reset", 32'(lock_level), 0);
        check(1, "dead after reset", 32'(dead_code), 0);
        check(1, "misc after reset", 32'(misc_v), 0);
        check(1, "idle/pol after reset", 32'({idle_v, pol_v}), 0);
        check(1, "modes after reset", 32'({oc_preload, oc_mode}), 0);

        for (int k = 0; k < 12; k++) begin
            do_write(VECS[k].addr, VECS[k].data, VECS[k].mask);
            check(int'(VECS[k].req), $sformatf("vec%0d lock", k), 32'(lock_level), 32'(VECS[k].e_lock));
            check(int'(VECS[k].req), $sformatf("vec%0d dead", k), 32'(dead_code), 32'(VECS[k].e_dead));
            check(int'(VECS[k].req), $sformatf("vec%0d misc", k), 32'(misc_v), 32'(VECS[k].e_misc));
            check(int'(VECS[k].req), $sformatf("vec%0d idle", k), 32'(idle_v), 32'(VECS[k].e_idle));
            check(int'(VECS[k].req), $sformatf("vec%0d pol", k), 32'(pol_v), 32'(VECS[k].e_pol));
            check(int'(VECS[k].req), $sformatf("vec%0d mode0", k), 32'(mode0_v), 32'(VECS[k].e_mode));
        end

        // R2 idle states writable at level 0; R5 level-0 lock write uses up the one write
        do_reset();
        check(1, "lock cleared by reset", 32'(lock_level), 0);
        do_write(3'd1, 16'h00A5, 16'h00FF);
        check(2, "idle write at level 0", 32'(idle_v), 32'hA5);
        do_write(3'd0, 16'h0000, 16'h0300);
        check(5, "lock after writing 0", 32'(lock_level), 0);
        do_write(3'd0, 16'h0300, 16'h0300);
        check(5, "raise after level-0 write", 32'(lock_level), 0);
        do_write(3'd0, 16'h0044, 16'h00FF);
        check(5, "dead still writable", 32'(dead_code), 32'h44);

        // R7 level 2
        do_reset();
        do_write(3'd0, 16'h0200, 16'h0300);
        check(7, "lock set to 2", 32'(lock_level), 2);
        do_write(3'd2, 16'h00FF, 16'h00FF);
        check(7, "polarity blocked", 32'(pol_v), 0);
        do_write(3'd0, 16'h0C00, 16'h0C00);
        check(7, "off-state bits blocked", 32'(misc_v), 0);
        do_write(3'd4, 16'h000F, 16'h000F);
        check(7, "mode ch1 open", 32'(mode1_v), 32'hF);

        // R8 level 3
        do_reset();
        check(1, "reset clears lock 2", 32'(lock_level), 0);
        do_write(3'd0, 16'h0300, 16'h0300);
        check(8, "lock set to 3", 32'(lock_level), 3);
        do_write(3'd3, 16'h000F, 16'h000F);
        check(8, "mode ch0 blocked", 32'(mode0_v), 0);
        do_write(3'd6, 16'h000F, 16'h000F);
        check(8, "mode ch3 blocked", 32'(mode3_v), 0);
        do_write(3'd1, 16'h00FF, 16'h00FF);
        check(6, "idle blocked at 3", 32'(idle_v), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule